// File: doc/BRIEF.md
# Gated Conversion Trigger Qualifier

This block decides when an ADC sequencer may begin a conversion. It takes two candidate trigger sources and passes at most one of them. The first is an asynchronous active-low convert request arriving from a board pin. The second is a single-cycle pulse from an on-chip sample-interval timer. The pin is resynchronized, and its falling edge is accepted only under two conditions: the line sat high for at least a programmable number of cycles beforehand, and it then stays low long enough to count as a real pulse. A low level that lasts any length beyond that minimum still yields exactly one start.

A source select chooses between the pin and the timer. The two share one physical convert node, so the block also produces an enable for the timer's output driver and a monitor copy of whatever is on that node. Every start is withheld in three cases: outside an acquisition sequence, while the active-low hardware gate is released (high), and while the software gate bit is clear. A start that qualifies while the converter reports busy is dropped and recorded in a sticky overrun flag.

Top module: `conv_trig_qual`

## Requirements
- R1: After synchronous reset, with the pin source selected (`src_sel`=0) and the pin held high, `soc` and `overrun` are 0, `conv_mon_n` is 1 and `timer_oe` is 0.
- R2: With `src_sel`=0, a pin falling edge is accepted under two conditions: the synchronized pin was high for at least `conv_period` cycles immediately before it, and it stays low for at least `MIN_LOW_CYC` cycles. An accepted edge gives one `soc` pulse, which is high in the cycle after clock edge number `MIN_LOW_CYC`+2, counted from the first edge that samples the pin low.
- R3: A low pulse shorter than `MIN_LOW_CYC` cycles produces no `soc`.
- R4: A low level of any length at or beyond the minimum produces exactly one `soc`.
- R5: A falling edge preceded by fewer than `conv_period` high cycles is ignored, even if the low then lasts long enough.
- R6: With `src_sel`=1, each `timer_pulse` cycle produces `soc` in the next cycle, and pin activity produces no `soc`.
- R7: With `src_sel`=0, `timer_pulse` produces no `soc` and `timer_oe` is 0. With `src_sel`=1, `timer_oe` is 1.
- R8: While `acq_active` is 0, no `soc` is issued from either source.
- R9: While `hw_gate_n` is 1, or while `sw_gate` is 0, no `soc` is issued.
- R10: A trigger that qualifies while `adc_busy` is 1 issues no `soc` and sets `overrun`. `overrun` then stays at 1 until reset.
- R11: `conv_mon_n` equals the inverse of `timer_pulse` when `src_sel`=1. When `src_sel`=0 it equals the synchronized pin level, which lags the pin by two clock edges.
- R12: `soc` is never high in two consecutive cycles; a timer pulse held for two cycles yields a single `soc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_conv_n | input | 1 | Asynchronous active-low convert request from the pin |
| timer_pulse | input | 1 | Sample-interval timer pulse |
| src_sel | input | 1 | Trigger source: 0 pin, 1 timer |
| conv_period | input | PERIOD_W | Minimum idle-high time before a pin edge, in cycles |
| acq_active | input | 1 | Acquisition sequence in progress |
| hw_gate_n | input | 1 | Active-low hardware gate, 0 allows conversions |
| sw_gate | input | 1 | Software gate bit, 1 allows conversions |
| adc_busy | input | 1 | Converter still busy with the previous sample |
| soc | output | 1 | One-cycle start-of-conversion strobe |
| overrun | output | 1 | Sticky flag: a trigger arrived while busy |
| timer_oe | output | 1 | Output enable for the timer's driver onto the convert node |
| conv_mon_n | output | 1 | Monitor copy of the active-low convert node |

## Verification
Four behaviours are checked by assertions on every clock edge: the strobe never lasts two cycles, no strobe follows a cycle with the acquisition window closed or either gate released, no strobe follows a busy cycle, and the overrun flag never clears on its own. Whether a pin pulse is accepted depends on how long the pin stayed high and then low, so only the bench's scenarios can show it. The bench sweeps both durations around the two thresholds, in a near-exhaustive way, and also measures the exact strobe latency, the single start from a very long low, source exclusivity and the monitor path.

// File: rtl/ctq_pkg.sv
package ctq_pkg;

    typedef enum logic {
        SRC_PIN   = 1'b0,
        SRC_TIMER = 1'b1
    } trig_src_e;

    typedef struct packed {
        logic acq;
        logic hw_open;
        logic sw_open;
        logic busy;
    } gate_s;

    function automatic logic gates_open(gate_s g);
        return g.acq & g.hw_open & g.sw_open;
    endfunction

endpackage

// File: rtl/ctq_sync.sv
module ctq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ctq_pin_qual.sv
module ctq_pin_qual #(
    parameter int MIN_LOW_CYC = 7,
    parameter int PERIOD_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_s,
    input  logic [PERIOD_W-1:0] conv_period,
    output logic                trig
);
    localparam int LOW_W = $clog2(MIN_LOW_CYC + 1);
    localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(MIN_LOW_CYC - 1);
    localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(MIN_LOW_CYC);

    logic [PERIOD_W-1:0] hi_run;
    logic [LOW_W-1:0]    lo_run;
    logic                armed;
    logic                first_low;
    logic                edge_ok;

    assign first_low = !pin_s && (lo_run == '0);
    assign edge_ok   = first_low ? (hi_run >= conv_period) : armed;
    assign trig      = !pin_s && edge_ok && (lo_run == LOW_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
            armed  <= 1'b0;
        end else if (pin_s) begin
            if (hi_run != '1) hi_run <= hi_run + 1'b1;
            lo_run <= '0;
            armed  <= 1'b0;
        end else begin
            hi_run <= '0;
            if (first_low) armed <= (hi_run >= conv_period);
            if (lo_run < LOW_SAT) lo_run <= lo_run + 1'b1;
        end
    end
endmodule

// File: rtl/ctq_gate.sv
module ctq_gate
    import ctq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_src_e src,
    input  logic      pin_trig,
    input  logic      timer_pulse,
    input  gate_s     gates,
    output logic      soc,
    output logic      overrun
);
    logic cand;
    logic fire;

    assign cand = (src == SRC_TIMER) ? timer_pulse : pin_trig;
    assign fire = cand & gates_open(gates) & ~soc;

    always_ff @(posedge clk) begin
        if (rst) begin
            soc     <= 1'b0;
            overrun <= 1'b0;
        end else begin
            soc <= fire & ~gates.busy;
            if (fire & gates.busy) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/conv_trig_qual.sv
module conv_trig_qual
    import ctq_pkg::*;
#(
    parameter int MIN_LOW_CYC = 7,
    parameter int PERIOD_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_conv_n,
    input  logic                timer_pulse,
    input  logic                src_sel,
    input  logic [PERIOD_W-1:0] conv_period,
    input  logic                acq_active,
    input  logic                hw_gate_n,
    input  logic                sw_gate,
    input  logic                adc_busy,
    output logic                soc,
    output logic                overrun,
    output logic                timer_oe,
    output logic                conv_mon_n
);
    trig_src_e src;
    gate_s     gates;
    logic      pin_s;
    logic      pin_trig;

    assign src   = trig_src_e'(src_sel);
    assign gates = '{acq: acq_active, hw_open: ~hw_gate_n,
                     sw_open: sw_gate, busy: adc_busy};

    ctq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_conv_n),
        .q   (pin_s)
    );

    ctq_pin_qual #(.MIN_LOW_CYC(MIN_LOW_CYC), .PERIOD_W(PERIOD_W)) u_qual (
        .clk         (clk),
        .rst         (rst),
        .pin_s       (pin_s),
        .conv_period (conv_period),
        .trig        (pin_trig)
    );

    ctq_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .src         (src),
        .pin_trig    (pin_trig),
        .timer_pulse (timer_pulse),
        .gates       (gates),
        .soc         (soc),
        .overrun     (overrun)
    );

    assign timer_oe   = (src == SRC_TIMER);
    assign conv_mon_n = (src == SRC_TIMER) ? ~timer_pulse : pin_s;
endmodule

// File: rtl/ctq_checker.sv
module ctq_checker (
    input logic clk,
    input logic rst,
    input logic acq_active,
    input logic hw_gate_n,
    input logic sw_gate,
    input logic adc_busy,
    input logic soc,
    input logic overrun
);
    assert_single_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        soc |=> !soc);

    assert_acq_window_R8: assert property (@(posedge clk) disable iff (rst)
        !acq_active |=> !soc);

    assert_gate_block_R9: assert property (@(posedge clk) disable iff (rst)
        (hw_gate_n || !sw_gate) |=> !soc);

    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (rst)
        adc_busy |=> !soc);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

bind conv_trig_qual ctq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .acq_active (acq_active),
    .hw_gate_n  (hw_gate_n),
    .sw_gate    (sw_gate),
    .adc_busy   (adc_busy),
    .soc        (soc),
    .overrun    (overrun)
);

// File: tb/tb_conv_trig_qual.sv
module tb_conv_trig_qual;
    localparam int MIN_LOW = 3;
    localparam int PW      = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pin_conv_n = 1'b1;
    logic          timer_pulse = 1'b0;
    logic          src_sel = 1'b0;
    logic [PW-1:0] conv_period = PW'(5);
    logic          acq_active = 1'b1;
    logic          hw_gate_n = 1'b0;
    logic          sw_gate = 1'b1;
    logic          adc_busy = 1'b0;
    logic          soc, overrun, timer_oe, conv_mon_n;

    int n_cmp = 0;
    int n_bad = 0;
    int soc_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    conv_trig_qual #(.MIN_LOW_CYC(MIN_LOW), .PERIOD_W(PW)) dut (
        .clk(clk), .rst(rst), .pin_conv_n(pin_conv_n), .timer_pulse(timer_pulse),
        .src_sel(src_sel), .conv_period(conv_period), .acq_active(acq_active),
        .hw_gate_n(hw_gate_n), .sw_gate(sw_gate), .adc_busy(adc_busy),
        .soc(soc), .overrun(overrun), .timer_oe(timer_oe), .conv_mon_n(conv_mon_n)
    );

    always @(posedge clk) begin
        #1;
        if (soc) soc_cnt++;
    end

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pin_trial(int h, int l, int exp, string req);
        int base;
        @(negedge clk) pin_conv_n = 1'b0;
        repeat (MIN_LOW + 6) @(negedge clk);
        pin_conv_n = 1'b1;
        base = soc_cnt;
        repeat (h) @(negedge clk);
        pin_conv_n = 1'b0;
        repeat (l) @(negedge clk);
        pin_conv_n = 1'b1;
        repeat (12) @(negedge clk);
        check(req, soc_cnt - base, exp);
    endtask

    task automatic timer_burst(int k, int hold, int exp, string req);
        int base;
        base = soc_cnt;
        for (int i = 0; i < k; i++) begin
            @(negedge clk) timer_pulse = 1'b1;
            repeat (hold) @(negedge clk);
            timer_pulse = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check(req, soc_cnt - base, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 soc", soc, 0);
        check("R1 overrun", overrun, 0);
        check("R1 conv_mon_n", conv_mon_n, 1);
        check("R1 timer_oe", timer_oe, 0);

        // R2 R3 R5: sweep high and low durations around both thresholds
        for (int p = 2; p <= 5; p += 3) begin
            conv_period = PW'(p);
            for (int h = (p > 2 ? p - 2 : 1); h <= p + 2; h++) begin
                for (int l = 1; l <= MIN_LOW + 2; l++) begin
                    pin_trial(h, l, (h >= p && l >= MIN_LOW) ? 1 : 0,
                              (l < MIN_LOW) ? "R3" : ((h < p) ? "R5" : "R2"));
                end
            end
        end
        conv_period = PW'(5);

        // R4 very long low gives one strobe
        pin_trial(6, 40, 1, "R4");
        pin_trial(4, 40, 0, "R5 long low after short high");

        // R2 exact latency
        repeat (8) @(negedge clk);
        pin_conv_n = 1'b0;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            #1;
            n++;
            if (soc) break;
        end
        check("R2 latency", n, MIN_LOW + 2);
        @(negedge clk) pin_conv_n = 1'b1;
        repeat (10) @(negedge clk);

        // R7 timer ignored with pin source
        timer_burst(3, 1, 0, "R7 timer ignored");

        // R8 R9 pin gated
        acq_active = 1'b0; pin_trial(6, 5, 0, "R8 pin"); acq_active = 1'b1;
        hw_gate_n = 1'b1;  pin_trial(6, 5, 0, "R9 hw gate"); hw_gate_n = 1'b0;
        sw_gate = 1'b0;    pin_trial(6, 5, 0, "R9 sw gate"); sw_gate = 1'b1;

        // R6 timer source
        @(negedge clk) src_sel = 1'b1;
        #1;
        check("R7 timer_oe", timer_oe, 1);
        timer_burst(4, 1, 4, "R6 timer pulses");
        pin_trial(6, 5, 0, "R6 pin ignored");

        // R11 monitor
        @(negedge clk) timer_pulse = 1'b1;
        #1;
        check("R11 mon timer high", conv_mon_n, 0);
        @(negedge clk) timer_pulse = 1'b0;
        #1;
        check("R11 mon timer low", conv_mon_n, 1);

        // R12 held pulse
        timer_burst(1, 2, 1, "R12 held pulse");

        // R8 R9 timer gated
        acq_active = 1'b0; timer_burst(2, 1, 0, "R8 timer"); acq_active = 1'b1;
        hw_gate_n = 1'b1;  timer_burst(2, 1, 0, "R9 timer hw"); hw_gate_n = 1'b0;
        sw_gate = 1'b0;    timer_burst(2, 1, 0, "R9 timer sw"); sw_gate = 1'b1;

        // R10 busy
        check("R10 overrun before", overrun, 0);
        adc_busy = 1'b1;
        timer_burst(1, 1, 0, "R10 busy drop");
        check("R10 overrun set", overrun, 1);
        adc_busy = 1'b0;
        timer_burst(1, 1, 1, "R10 after busy");
        check("R10 overrun sticky", overrun, 1);

        // R11 pin monitor path
        @(negedge clk) src_sel = 1'b0;
        pin_conv_n = 1'b0;
        @(negedge clk);
        check("R11 mon pin one edge", conv_mon_n, 1);
        @(negedge clk);
        check("R11 mon pin two edges", conv_mon_n, 0);
        pin_conv_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset clears overrun
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 overrun cleared", overrun, 0);
        check("R1 soc after reset", soc, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule